// File: doc/BRIEF.md
# Chip-Select Timing Sequencer

This block sits between a serial flash transfer engine and the chip-select pins. It owns the timing around the select line. When a request is accepted, it picks one of several select lines. If the target device differs from the one used last, it first waits out a device-switch gap. It then pulls the line low and waits a programmed setup time. Only after that does it let the engine start the serial clock. When the engine reports the end of its transfer, the block keeps the line low for a hold time. It then releases the line and enforces a minimum high time before it will accept the next request.

All four delays are 8-bit values counted in reference clock cycles, and they arrive packed in one 32-bit word. The hold time and the minimum high time carry fixed built-in extra cycles. These extras depend on the serial clock period, which is derived from a small divider value. A programmed zero therefore still leaves the fixed part. The delay word and the divider are captured when a request is accepted, so software may rewrite them while a transfer runs.

Top module: `cs_timing_seq`

## Requirements
- R1: After reset `ready` is 1, every `cs_n` line is 1 and `sclk_en` is 0.
- R2: `delay_cfg` holds setup delay in bits 7:0, hold delay in bits 15:8, device-switch gap in bits 23:16 and minimum high time in bits 31:24. The serial clock period P equals 2*(`sclk_div`+1) reference cycles.
- R3: A request is taken when `req_valid` is 1 in a cycle where `ready` is 1, and `ready` is 0 in the following cycle. `req_valid` in a cycle with `ready` at 0 has no effect on any output.
- R4: The selected line `cs_n[req_cs]` goes low once any switch gap ends. It stays low for setup+1 cycles with `sclk_en` at 0, and `sclk_en` rises in the next cycle.
- R5: `sclk_en` stays 1 with the line low until `xfer_done` is 1 at a clock edge, and it is 0 from the next cycle on.
- R6: After `sclk_en` falls, the line stays low for hold+P+3 cycles.
- R7: After the line is released, all lines stay high and `ready` stays 0 for high+P+1 cycles. `ready` is 1 in the cycle after that.
- R8: If the new `req_cs` differs from the previous transfer's line, all lines stay high for `gap` cycles after acceptance before the setup phase. There is no gap for the first transfer after reset, for the same line, or when `gap` is 0.
- R9: Changes to `delay_cfg`, `sclk_div` and `req_cs` after acceptance do not alter the running transfer.
- R10: At most one `cs_n` line is low at any time, and none while `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_cfg | input | 32 | Packed delay word (setup, hold, gap, high minimum) |
| sclk_div | input | DIV_W (4) | Serial clock divider; period is 2*(value+1) cycles |
| req_valid | input | 1 | Transfer request |
| req_cs | input | IDX_W (2) | Index of the select line to drive |
| xfer_done | input | 1 | Engine reports the last serial clock edge |
| ready | output | 1 | Block accepts a request this cycle |
| cs_n | output | NUM_CS (4) | Active-low select lines |
| sclk_en | output | 1 | Engine may run the serial clock |

## Verification
The bench builds the block with its defaults: four select lines, 8-bit delays and a 4-bit divider. This lets it rotate among all four lines and exercise the switch gap in both its taken and skipped cases. It runs each delay from zero up to 255 with the divider from zero up to 15, so the largest phase of 255+32+3 cycles is reached. Back-to-back requests, one-cycle transfers, and garbage requests plus configuration churn during busy periods are all covered.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int unsigned DLY_W = 8;

    // Packed so that the first member lands in the top byte of the word (R2)
    typedef struct packed {
        logic [DLY_W-1:0] high_min;  // 31:24
        logic [DLY_W-1:0] gap;       // 23:16
        logic [DLY_W-1:0] hold;      // 15:8
        logic [DLY_W-1:0] setup;     // 7:0
    } delay_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_SETUP,
        PH_ACTIVE,
        PH_HOLD,
        PH_HIGH
    } phase_e;
endpackage

// File: rtl/cst_phase_len.sv
module cst_phase_len
    import cst_pkg::*;
#(
    parameter int unsigned DIV_W = 4,
    parameter int unsigned CNT_W = 14
) (
    input  phase_e           phase,
    input  delay_cfg_t       cfg,
    input  logic [DIV_W-1:0] div,
    output logic [CNT_W-1:0] load_val
);
    logic [CNT_W-1:0] sclk_period;

    always_comb begin
        sclk_period = (CNT_W'(div) + CNT_W'(1)) << 1;
        // Load value is phase length minus one; the timer expires at zero.
        case (phase)
            PH_GAP:   load_val = CNT_W'(cfg.gap) - CNT_W'(1);
            PH_SETUP: load_val = CNT_W'(cfg.setup);
            PH_HOLD:  load_val = CNT_W'(cfg.hold) + sclk_period + CNT_W'(2);
            PH_HIGH:  load_val = CNT_W'(cfg.high_min) + sclk_period;
            default:  load_val = '0;
        endcase
    end
endmodule

// File: rtl/cst_timer.sv
module cst_timer #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/cst_cs_drive.sv
module cst_cs_drive #(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              active,
    input  logic [IDX_W-1:0]  idx,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign cs_n[i] = !(active && (idx == IDX_W'(i)));
    end
endmodule

// File: rtl/cs_timing_seq.sv
module cs_timing_seq
    import cst_pkg::*;
#(
    parameter int unsigned NUM_CS = 4,
    parameter int unsigned DIV_W  = 4,
    parameter int unsigned IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       delay_cfg,
    input  logic [DIV_W-1:0]  sclk_div,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_cs,
    input  logic              xfer_done,
    output logic              ready,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sclk_en
);
    localparam int unsigned CNT_W = DLY_W + DIV_W + 2;

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] cs;
        delay_cfg_t       cfg;
        logic [DIV_W-1:0] div;
        logic             have_last;
    } seq_t;

    seq_t             st_d, st_q;
    delay_cfg_t       live_cfg, cfg_sel;
    logic [DIV_W-1:0] div_sel;
    logic [CNT_W-1:0] load_val;
    logic             tmr_load, tmr_expired;
    logic             cs_active;

    assign live_cfg = delay_cfg_t'(delay_cfg);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: if (req_valid) begin
                st_d.cs        = req_cs;
                st_d.cfg       = live_cfg;
                st_d.div       = sclk_div;
                st_d.have_last = 1'b1;
                if (st_q.have_last && req_cs != st_q.cs && live_cfg.gap != '0)
                    st_d.phase = PH_GAP;
                else
                    st_d.phase = PH_SETUP;
            end
            PH_GAP:    if (tmr_expired) st_d.phase = PH_SETUP;
            PH_SETUP:  if (tmr_expired) st_d.phase = PH_ACTIVE;
            PH_ACTIVE: if (xfer_done)   st_d.phase = PH_HOLD;
            PH_HOLD:   if (tmr_expired) st_d.phase = PH_HIGH;
            PH_HIGH:   if (tmr_expired) st_d.phase = PH_IDLE;
            default:   st_d.phase = PH_IDLE;
        endcase

        // Live settings only matter on the acceptance cycle; later the snapshot rules.
        cfg_sel  = (st_q.phase == PH_IDLE) ? live_cfg : st_q.cfg;
        div_sel  = (st_q.phase == PH_IDLE) ? sclk_div : st_q.div;
        tmr_load = (st_d.phase != st_q.phase) &&
                   (st_d.phase inside {PH_GAP, PH_SETUP, PH_HOLD, PH_HIGH});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cs: '0, cfg: '0, div: '0, have_last: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    cst_phase_len #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_len (
        .phase    (st_d.phase),
        .cfg      (cfg_sel),
        .div      (div_sel),
        .load_val (load_val)
    );

    cst_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (load_val),
        .expired  (tmr_expired)
    );

    assign cs_active = st_q.phase inside {PH_SETUP, PH_ACTIVE, PH_HOLD};

    cst_cs_drive #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_drive (
        .active (cs_active),
        .idx    (st_q.cs),
        .cs_n   (cs_n)
    );

    assign ready   = (st_q.phase == PH_IDLE);
    assign sclk_en = (st_q.phase == PH_ACTIVE);

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R10
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (&cs_n));
    // R5
    sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> ($countones(~cs_n) == 1));
    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);
    // R5
    active_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_en && !xfer_done) |=> sclk_en);
    // R6
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_en) |-> !(&cs_n));
    // R9
    cs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready) && !(&cs_n) && !(&$past(cs_n))) |-> $stable(cs_n));
endmodule

// File: tb/test_cs_timing_seq.sv
`timescale 1ns/1ps
module test_cs_timing_seq;
    localparam int NCS = 4;
    localparam int DW  = 4;
    localparam int IW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [31:0]    delay_cfg = '0;
    logic [DW-1:0]  sclk_div = '0;
    logic           req_valid = 1'b0;
    logic [IW-1:0]  req_cs = '0;
    logic           xfer_done = 1'b0;
    logic           ready;
    logic [NCS-1:0] cs_n;
    logic           sclk_en;

    always #2 clk = ~clk;

    cs_timing_seq #(.NUM_CS(NCS), .DIV_W(DW)) i_cs_timing_seq (
        .clk, .rst_n, .delay_cfg, .sclk_div, .req_valid, .req_cs,
        .xfer_done, .ready, .cs_n, .sclk_en
    );

    typedef struct {
        bit             rdy;
        logic [NCS-1:0] csn;
        bit             sck;
        bit             done;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    bit   have_last = 0;
    int   last_cs = 0;
    bit   junk = 0;
    int   cyc = 0;

    function automatic logic [NCS-1:0] low_of(int c);
        return ~(NCS'(1) << c);
    endfunction

    task automatic push(int n, bit rdy, logic [NCS-1:0] csn, bit sck, bit done, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.rdy = rdy; e.csn = csn; e.sck = sck; e.done = done; e.tag = tag;
            q.push_back(e);
        end
    endtask

    // One cycle of the reference model: compare (R10 shape included), then drive.
    task automatic step(output bit cur_ready);
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.rdy = 1; e.csn = '1; e.sck = 0; e.done = 0; e.tag = "R3";
        end
        checks++;
        if (ready !== e.rdy || cs_n !== e.csn || sclk_en !== e.sck) begin
            errors++;
            $display("FAIL %s: ready/cs_n/sclk_en got %b/%b/%b expected %b/%b/%b at %0t",
                     e.tag, ready, cs_n, sclk_en, e.rdy, e.csn, e.sck, $time);
        end
        xfer_done = e.done;
        cur_ready = e.rdy;
        if (e.rdy) req_valid = 1'b0;
        else begin
            // R3 and R9: garbage request and settings churn while busy
            req_valid = junk;
            if (junk) begin
                req_cs    = IW'($urandom);
                delay_cfg = $urandom;
                sclk_div  = DW'($urandom);
            end
        end
    endtask

    task automatic do_xfer(int c, int su, int ho, int ga, int hi, int dv, int len, bit jk);
        bit r;
        int p, gn;
        r = 0;
        while (!r) step(r);
        req_valid = 1'b1;
        req_cs    = IW'(c);
        // R2: setup 7:0, hold 15:8, gap 23:16, high minimum 31:24
        delay_cfg = {8'(hi), 8'(ga), 8'(ho), 8'(su)};
        sclk_div  = DW'(dv);
        p  = 2 * (dv + 1);
        gn = (have_last && c != last_cs && ga != 0) ? ga : 0;
        push(gn, 0, '1, 0, 0, "R8");
        push(su + 1, 0, low_of(c), 0, 0, "R4");
        push(len - 1, 0, low_of(c), 1, 0, "R5");
        push(1, 0, low_of(c), 1, 1, "R5");
        push(ho + p + 3, 0, low_of(c), 0, 0, "R6");
        push(hi + p + 1, 0, '1, 0, 0, "R7");
        have_last = 1;
        last_cs   = c;
        junk      = jk;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: cycles got %0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        bit r;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (ready !== 1'b1 || cs_n !== '1 || sclk_en !== 1'b0) begin
            errors++;
            $display("FAIL R1: ready/cs_n/sclk_en got %b/%b/%b expected 1/1111/0",
                     ready, cs_n, sclk_en);
        end
        rst_n = 1'b1;

        do_xfer(0, 0, 0, 0, 0, 0, 1, 0);      // minimum delays, first transfer: no gap (R8)
        do_xfer(0, 3, 2, 50, 5, 1, 4, 1);     // same line: no gap; junk while busy (R3, R9)
        do_xfer(2, 0, 0, 7, 0, 3, 2, 0);      // line change: gap taken (R8)
        do_xfer(1, 10, 9, 0, 12, 15, 6, 1);   // line change, gap zero (R8)
        do_xfer(3, 255, 255, 255, 255, 15, 3, 1); // largest phases (R4, R6, R7)
        do_xfer(0, 1, 1, 1, 1, 0, 1, 0);      // one-cycle gap
        for (int k = 0; k < 12; k++)
            do_xfer($urandom_range(0, NCS - 1), $urandom_range(0, 40), $urandom_range(0, 40),
                    $urandom_range(0, 20), $urandom_range(0, 40), $urandom_range(0, 15),
                    $urandom_range(1, 9), k[0]);
        while (q.size() > 0) step(r);
        junk = 0;
        repeat (4) step(r);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule